// File: doc/BRIEF.md
# External Wake-Up and Interrupt Conditioner

This block turns a bank of asynchronous event lines into interrupt requests for a vectored interrupt controller and into a single wake-up request for a sleeping processor. The lines are external pins plus a real-time-clock line and a USB-resume line. Each line passes through a synchronizer and an edge detector. The detector watches for a rising or a falling edge, chosen per line. An unmasked edge sets a sticky pending bit. Software clears that bit by writing a one to its position.

From the pending bits the block builds its outputs. Output 0 is a summary interrupt: the OR of every unmasked, interrupt-enabled pending line. The lines are grouped into ports of `PORT_W` lines each. Every port drives one more output, which carries a single line of that port picked by a per-port index, and that output is active only while its port selection is switched on. A separate wake-up output ORs the unmasked pending lines that are enabled for wake-up. Whether a line acts as an interrupt, as a wake-up source or as both is decided per line by two enable vectors.

All outputs are decoded directly from the pending register and the configuration inputs, with no bus read in the path. They therefore keep asserting from an always-on clock while the bus clock is stopped.

Top module: `wkp_unit`

## Requirements
- R1: After reset the pending vector is all zero and every interrupt output and the wake-up output are low.
- R2: A line whose `cfg_rise` bit is 1 sets its pending bit on a 0-to-1 change and not on a 1-to-0 change. The bit reads as set after the third rising clock edge that follows the change.
- R3: A line whose `cfg_rise` bit is 0 sets its pending bit on a 1-to-0 change and not on a 0-to-1 change.
- R4: A line whose `cfg_unmask` bit is 0 never sets its pending bit, and a pending bit whose line is masked drives no output.
- R5: Pending bits stay set until a clock edge with `clr_we` high and a 1 in the matching `clr_bits` position. Positions holding 0 are left unchanged.
- R6: When a new edge and a clear of the same bit land on the same clock edge, the bit ends up set.
- R7: `irq_o[0]` is high exactly when at least one pending bit is both unmasked and enabled in `cfg_irq_en`.
- R8: For port k, `irq_o[k+1]` follows the pending bit of line `PORT_W*k + port_sel[k]` when `port_sel_en[k]` is 1 and that line is unmasked and interrupt-enabled. When `port_sel_en[k]` is 0 the output is low. `port_sel` holds one SEL_W-bit field per port, with port 0 in the lowest bits.
- R9: `wake_o` is high exactly when at least one pending bit is unmasked and enabled in `cfg_wake_en`. A line enabled only for wake-up drives no interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | NUM_IN | Asynchronous event lines |
| cfg_rise | input | NUM_IN | 1 = rising edge triggers, 0 = falling edge triggers |
| cfg_unmask | input | NUM_IN | 1 = line in use, 0 = line masked |
| cfg_irq_en | input | NUM_IN | Line feeds the interrupt outputs |
| cfg_wake_en | input | NUM_IN | Line feeds the wake-up output |
| port_sel | input | NUM_PORTS*SEL_W | Per-port line index, port 0 in the lowest field |
| port_sel_en | input | NUM_PORTS | Per-port selection enable |
| clr_we | input | 1 | Write strobe for pending clear |
| clr_bits | input | NUM_IN | Write-one-to-clear mask |
| pend_o | output | NUM_IN | Pending vector |
| irq_o | output | NUM_PORTS+1 | Summary interrupt (bit 0) and per-port selected interrupts |
| wake_o | output | 1 | Wake-up request |

## Verification
An edge that is just being latched and a software clear of the same pending bit can take effect on the same clock edge. The bench provokes this by raising a line and issuing the clear write two edges later, so that the clear strobe coincides with the third edge, where the set happens. The same write also clears an unrelated pending bit. The design is judged correct when the colliding bit survives and the unrelated bit is gone. This shows that the clear itself took effect and that only the set won on the contested position.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
   localparam int unsigned WKP_MIN_SYNC = 2;
   typedef enum logic {
      TRIG_FALL = 1'b0,
      TRIG_RISE = 1'b1
   } trig_e;
endpackage

// File: rtl/wkp_edge_det.sv
module wkp_edge_det
   import wkp_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_async,
   input  logic trig_rise,
   output logic hit
);
   if (SYNC_STAGES < WKP_MIN_SYNC) begin : g_bad_sync
      $error("wkp_edge_det: SYNC_STAGES below minimum");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   now_lvl;
   trig_e                  mode;

   assign now_lvl = sync_q[SYNC_STAGES-1];
   assign mode    = trig_e'(trig_rise);

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
         last_q <= now_lvl;
      end
   end

   always_comb begin
      unique case (mode)
         TRIG_RISE: hit = now_lvl & ~last_q;
         default:   hit = ~now_lvl & last_q;
      endcase
   end
endmodule

// File: rtl/wkp_pend.sv
module wkp_pend #(
   parameter int unsigned NUM_IN = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_IN-1:0] set_vec,
   input  logic              clr_we,
   input  logic [NUM_IN-1:0] clr_bits,
   output logic [NUM_IN-1:0] pend
);
   logic [NUM_IN-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_bits : '0;

   always_ff @(posedge clk) begin
      if (rst) pend <= '0;
      else     pend <= (pend & ~clr_eff) | set_vec;
   end
endmodule

// File: rtl/wkp_route.sv
module wkp_route #(
   parameter int unsigned NUM_IN    = 32,
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned PORT_W    = 8,
   parameter int unsigned SEL_W     = 3
) (
   input  logic [NUM_IN-1:0]          pend,
   input  logic [NUM_IN-1:0]          cfg_unmask,
   input  logic [NUM_IN-1:0]          cfg_irq_en,
   input  logic [NUM_IN-1:0]          cfg_wake_en,
   input  logic [NUM_PORTS*SEL_W-1:0] port_sel,
   input  logic [NUM_PORTS-1:0]       port_sel_en,
   output logic [NUM_PORTS:0]         irq_o,
   output logic                       wake_o
);
   logic [NUM_IN-1:0] live;
   logic [NUM_IN-1:0] irq_live;

   assign live     = pend & cfg_unmask;
   assign irq_live = live & cfg_irq_en;
   assign irq_o[0] = |irq_live;
   assign wake_o   = |(live & cfg_wake_en);

   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      logic [PORT_W-1:0] slice;
      logic [SEL_W-1:0]  idx;
      assign slice       = irq_live[k*PORT_W +: PORT_W];
      assign idx         = port_sel[k*SEL_W +: SEL_W];
      assign irq_o[k+1]  = port_sel_en[k] & slice[idx];
   end
endmodule

// File: rtl/wkp_unit.sv
module wkp_unit #(
   parameter int unsigned NUM_IN      = 32,
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_IN-1:0]          pin_async,
   input  logic [NUM_IN-1:0]          cfg_rise,
   input  logic [NUM_IN-1:0]          cfg_unmask,
   input  logic [NUM_IN-1:0]          cfg_irq_en,
   input  logic [NUM_IN-1:0]          cfg_wake_en,
   input  logic [NUM_PORTS*SEL_W-1:0] port_sel,
   input  logic [NUM_PORTS-1:0]       port_sel_en,
   input  logic                       clr_we,
   input  logic [NUM_IN-1:0]          clr_bits,
   output logic [NUM_IN-1:0]          pend_o,
   output logic [NUM_PORTS:0]         irq_o,
   output logic                       wake_o
);
   if (NUM_PORTS * PORT_W != NUM_IN) begin : g_bad_ports
      $error("wkp_unit: NUM_PORTS*PORT_W must equal NUM_IN");
   end
   if (PORT_W < 2 || (1 << SEL_W) != PORT_W) begin : g_bad_portw
      $error("wkp_unit: PORT_W must be a power of two, at least 2");
   end

   logic [NUM_IN-1:0] hit;
   logic [NUM_IN-1:0] set_vec;

   for (genvar i = 0; i < NUM_IN; i++) begin : g_line
      wkp_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
         .clk       (clk),
         .rst       (rst),
         .pin_async (pin_async[i]),
         .trig_rise (cfg_rise[i]),
         .hit       (hit[i])
      );
   end

   assign set_vec = hit & cfg_unmask;

   wkp_pend #(.NUM_IN(NUM_IN)) u_pend (
      .clk      (clk),
      .rst      (rst),
      .set_vec  (set_vec),
      .clr_we   (clr_we),
      .clr_bits (clr_bits),
      .pend     (pend_o)
   );

   wkp_route #(
      .NUM_IN    (NUM_IN),
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W),
      .SEL_W     (SEL_W)
   ) u_route (
      .pend        (pend_o),
      .cfg_unmask  (cfg_unmask),
      .cfg_irq_en  (cfg_irq_en),
      .cfg_wake_en (cfg_wake_en),
      .port_sel    (port_sel),
      .port_sel_en (port_sel_en),
      .irq_o       (irq_o),
      .wake_o      (wake_o)
   );
endmodule

// File: rtl/wkp_unit_chk.sv
module wkp_unit_chk #(
   parameter int unsigned NUM_IN    = 32,
   parameter int unsigned NUM_PORTS = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NUM_IN-1:0]    cfg_unmask,
   input logic [NUM_IN-1:0]    cfg_wake_en,
   input logic [NUM_PORTS-1:0] port_sel_en,
   input logic                 clr_we,
   input logic [NUM_IN-1:0]    clr_bits,
   input logic [NUM_IN-1:0]    pend_o,
   input logic [NUM_PORTS:0]   irq_o,
   input logic                 wake_o
);
   // R1
   reset_clean_chk: assert property (@(posedge clk)
      rst |=> (pend_o == '0));

   // R5
   sticky_pend_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (($past(pend_o) & ~pend_o & ~($past(clr_we) ? $past(clr_bits) : '0)) == '0));

   // R4
   masked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(cfg_unmask)) == '0));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_o == '0) |-> (irq_o == '0 && !wake_o));

   // R9
   wake_source_chk: assert property (@(posedge clk) disable iff (rst)
      wake_o |-> ((pend_o & cfg_unmask & cfg_wake_en) != '0));

   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_sel
      // R8
      sel_off_chk: assert property (@(posedge clk) disable iff (rst)
         !port_sel_en[k] |-> !irq_o[k+1]);
   end
endmodule

bind wkp_unit wkp_unit_chk #(.NUM_IN(NUM_IN), .NUM_PORTS(NUM_PORTS)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cfg_unmask  (cfg_unmask),
   .cfg_wake_en (cfg_wake_en),
   .port_sel_en (port_sel_en),
   .clr_we      (clr_we),
   .clr_bits    (clr_bits),
   .pend_o      (pend_o),
   .irq_o       (irq_o),
   .wake_o      (wake_o)
);

// File: tb/wkp_unit_tb.sv
module wkp_unit_tb;
   localparam int N  = 32;
   localparam int NP = 4;
   localparam int PW = 8;
   localparam int SW = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst;
   logic [N-1:0]      pin_async, cfg_rise, cfg_unmask, cfg_irq_en, cfg_wake_en, clr_bits;
   logic [NP*SW-1:0]  port_sel;
   logic [NP-1:0]     port_sel_en;
   logic              clr_we;
   logic [N-1:0]      pend_o;
   logic [NP:0]       irq_o;
   logic              wake_o;

   wkp_unit u_dut (
      .clk(clk), .rst(rst), .pin_async(pin_async), .cfg_rise(cfg_rise),
      .cfg_unmask(cfg_unmask), .cfg_irq_en(cfg_irq_en), .cfg_wake_en(cfg_wake_en),
      .port_sel(port_sel), .port_sel_en(port_sel_en), .clr_we(clr_we),
      .clr_bits(clr_bits), .pend_o(pend_o), .irq_o(irq_o), .wake_o(wake_o)
   );

   typedef struct packed {
      logic [N-1:0] pend;
      logic [NP:0]  irq;
      logic         wake;
   } exp_t;

   exp_t         exp_q[$];
   string        tag_q[$];
   int           n_cmp = 0;
   int           n_bad = 0;
   bit           done  = 1'b0;
   event         chk_ev;
   logic [N-1:0] m_pend;

   // Expected outputs derived from R7, R8, R9
   function automatic exp_t predict();
      exp_t         e;
      logic [N-1:0] live;
      e.pend     = m_pend;
      live       = m_pend & cfg_unmask;
      e.irq[0]   = |(live & cfg_irq_en);
      for (int k = 0; k < NP; k++) begin
         int idx = k*PW + int'(port_sel[k*SW +: SW]);
         e.irq[k+1] = port_sel_en[k] & live[idx] & cfg_irq_en[idx];
      end
      e.wake     = |(live & cfg_wake_en);
      return e;
   endfunction

   task automatic push_check(input string tag);
      #1;
      exp_q.push_back(predict());
      tag_q.push_back(tag);
      -> chk_ev;
      #1;
   endtask

   task automatic drive_pin(input int i, input logic v, input bit sets, input string tag);
      pin_async[i] = v;
      repeat (3) @(posedge clk);
      if (sets) m_pend[i] = 1'b1;
      push_check(tag);
   endtask

   task automatic clear(input logic [N-1:0] bits, input string tag);
      clr_bits = bits;
      clr_we   = 1'b1;
      @(posedge clk);
      #1 clr_we = 1'b0;
      m_pend &= ~bits;
      push_check(tag);
   endtask

   // monitor
   initial begin
      forever begin
         exp_t  e;
         string t;
         @(chk_ev);
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_cmp++;
         if (pend_o !== e.pend || irq_o !== e.irq || wake_o !== e.wake) begin
            n_bad++;
            $display("FAIL %s: pend=%h/%h irq=%b/%b wake=%b/%b (actual/expected)",
                     t, pend_o, e.pend, irq_o, e.irq, wake_o, e.wake);
         end
      end
   end

   // watchdog
   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst         = 1'b1;
      pin_async   = '0;
      cfg_rise    = ~32'h0000_FF00;
      cfg_unmask  = ~32'h0000_0020;
      cfg_irq_en  = ~(32'h1 << 20);
      cfg_wake_en = (32'h1 << 20) | (32'h1 << 3);
      port_sel    = {3'd6, 3'd4, 3'd2, 3'd3};
      port_sel_en = 4'b0111;
      clr_we      = 1'b0;
      clr_bits    = '0;
      m_pend      = '0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      push_check("R1 reset state");

      drive_pin(0, 1'b1, 1'b1, "R2 rising edge sets");
      drive_pin(0, 1'b0, 1'b0, "R2 falling edge ignored");
      clear(32'h1, "R5 write-one clears");
      drive_pin(5, 1'b1, 1'b0, "R4 masked line never sets");
      drive_pin(3, 1'b1, 1'b1, "R8 port 0 selection and R9 wake");
      drive_pin(10, 1'b1, 1'b0, "R3 rising edge ignored");
      drive_pin(10, 1'b0, 1'b1, "R3 falling edge sets");
      drive_pin(20, 1'b1, 1'b1, "R9 wake-only line");
      clear(32'h8, "R5 zeros leave other bits");
      drive_pin(30, 1'b1, 1'b1, "R8 disabled port stays low");
      port_sel_en[3] = 1'b1;
      push_check("R8 enabling port selection");

      // R6: clear lands on the same edge as the set of bit 1
      pin_async[1] = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      clr_bits = (32'h1 << 1) | (32'h1 << 30);
      clr_we   = 1'b1;
      @(posedge clk);
      #1 clr_we = 1'b0;
      m_pend[1]  = 1'b1;
      m_pend[30] = 1'b0;
      push_check("R6 set wins over clear");

      cfg_unmask[10] = 1'b0;
      push_check("R4 masked pending hidden");

      clear('1, "R5 clear all");
      drive_pin(31, 1'b1, 1'b1, "R7 summary from last line");
      drive_pin(31, 1'b0, 1'b0, "R2 falling edge ignored on last line");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule